// File: doc/BRIEF.md
# Circular Buffer Writer with Pointer Mirror

This block sits between a byte-wide serial receiver and a shared memory. Every byte it takes from the receiver is stored at the next slot of a circular region of that memory. Right after each byte, the block writes its updated write pointer into a fixed two-byte slot at the bottom of the same memory.

A host can poll that slot and compare the value with a read pointer of its own. It can then tell how many bytes are waiting, and whether it has fallen behind or run ahead. The pointer is published after every byte rather than once per block, so a stream that stops part-way through a block is still visible to the host.

All memory traffic goes out through one valid/ready write port. A single sequencer decides when that port carries the data byte and when it carries either half of the pointer.

Top module: `ring_ptr_writer`

## Requirements
- R1: After reset is released, the first two memory writes are address 0x0000 with data 0x02 and then address 0x0001 with data 0x00. `in_ready_o` stays low until both writes have been accepted.
- R2: Each accepted input byte produces exactly three memory writes, in this order: the data byte at the current write pointer, the low byte of the advanced pointer at 0x0000, and the high byte of the advanced pointer at 0x0001. The pointer is stored little-endian.
- R3: `in_ready_o` is high only while no memory write is pending. It falls in the cycle after an input byte is accepted and rises in the cycle after the 0x0001 write is accepted. While `in_ready_o` is low, `in_valid_i` and `in_data_i` have no effect.
- R4: Consecutive data bytes land at consecutive addresses, starting at 0x0002. The pointer advances by exactly one per byte.
- R5: After a data byte is written at 0x1000, the pointer wraps to 0x0002. The following mirror writes carry 0x02 and 0x00.
- R6: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o`, `mem_addr_o` and `mem_data_o` hold their values into the next cycle.
- R7: Every memory write goes either to 0x0000, to 0x0001, or to an address within 0x0002 to 0x1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Receiver byte valid |
| in_ready_o | output | 1 | Block can take a byte |
| in_data_i | input | 8 | Receiver byte |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | 16 | Byte address of the write |
| mem_data_o | output | 8 | Byte to write |

## Verification
Two events share a single cycle when the data write to the last slot, 0x1000, is accepted. In that cycle the data write completes and the pointer wraps. The next write must therefore already mirror 0x0002 and not 0x1001.

The bench reaches this case by streaming more than 4095 bytes under random memory back-pressure, so the wrap is hit with and without stalls around it. It judges each write against a reference queue. The queue is built from the byte count alone, and the pointer's wrap is applied there independently of the design.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  localparam int unsigned ADDR_W = 16;  // pointer mirror is two bytes
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_PLO,
    ST_PHI
  } wr_state_e;
endpackage

// File: rtl/ring_ptr_ctr.sv
module ring_ptr_ctr
  import ring_ptr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RING_LO = 16'h0002,
  parameter logic [ADDR_W-1:0] RING_HI = 16'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= RING_LO;
    else if (adv_i) ptr_q <= (ptr_q == RING_HI) ? RING_LO : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ring_ptr_seq.sv
module ring_ptr_seq
  import ring_ptr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_valid_i,
  input  logic      mem_ready_i,
  output wr_state_e state_o,
  output logic      in_take_o,
  output logic      ptr_adv_o
);
  wr_state_e state_q, state_d;

  // reset lands in ST_PLO so the initial pointer is mirrored first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PLO;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (in_valid_i)  state_d = ST_DATA;
      ST_DATA: if (mem_ready_i) state_d = ST_PLO;
      ST_PLO:  if (mem_ready_i) state_d = ST_PHI;
      ST_PHI:  if (mem_ready_i) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  assign state_o   = state_q;
  assign in_take_o = (state_q == ST_IDLE) && in_valid_i;
  assign ptr_adv_o = (state_q == ST_DATA) && mem_ready_i;
endmodule

// File: rtl/ring_ptr_writer.sv
module ring_ptr_writer
  import ring_ptr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RING_LO     = 16'h0002,
  parameter logic [ADDR_W-1:0] RING_HI     = 16'h1000,
  parameter logic [ADDR_W-1:0] MIRROR_BASE = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  localparam logic [ADDR_W-1:0] MIRROR_HI = MIRROR_BASE + 1'b1;

  wr_state_e         state;
  logic              in_take, ptr_adv;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] byte_q;

  ring_ptr_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .in_take_o   (in_take),
    .ptr_adv_o   (ptr_adv)
  );

  ring_ptr_ctr #(
    .RING_LO (RING_LO),
    .RING_HI (RING_HI)
  ) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (ptr_adv),
    .ptr_o  (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      byte_q <= '0;
    else if (in_take) byte_q <= in_data_i;
  end

  assign in_ready_o  = (state == ST_IDLE);
  assign mem_valid_o = (state != ST_IDLE);

  // write-port arbitration: data slot, then pointer low, then pointer high
  always_comb begin
    unique case (state)
      ST_DATA: begin mem_addr_o = ptr;         mem_data_o = byte_q;                   end
      ST_PLO:  begin mem_addr_o = MIRROR_BASE; mem_data_o = ptr[DATA_W-1:0];          end
      ST_PHI:  begin mem_addr_o = MIRROR_HI;   mem_data_o = ptr[ADDR_W-1:DATA_W];     end
      default: begin mem_addr_o = '0;          mem_data_o = '0;                       end
    endcase
  end
endmodule

// File: rtl/ring_ptr_chk.sv
module ring_ptr_chk
  import ring_ptr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RING_LO     = 16'h0002,
  parameter logic [ADDR_W-1:0] RING_HI     = 16'h1000,
  parameter logic [ADDR_W-1:0] MIRROR_BASE = 16'h0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o
);
  localparam logic [ADDR_W-1:0] MIRROR_HI = MIRROR_BASE + 1'b1;

  logic wr_fire;
  assign wr_fire = mem_valid_o && mem_ready_i;

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !mem_valid_o);

  p_accept_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> !in_ready_o && mem_valid_o && mem_addr_o >= RING_LO);

  p_hi_then_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && mem_addr_o == MIRROR_HI |=> in_ready_o);

  p_data_then_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && mem_addr_o >= RING_LO |=> mem_valid_o && mem_addr_o == MIRROR_BASE);

  p_lo_then_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && mem_addr_o == MIRROR_BASE |=> mem_valid_o && mem_addr_o == MIRROR_HI);

  p_wrap_mirror_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && mem_addr_o == RING_HI |=> mem_data_o == RING_LO[DATA_W-1:0]);

  p_addr_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_addr_o == MIRROR_BASE || mem_addr_o == MIRROR_HI ||
                    (mem_addr_o >= RING_LO && mem_addr_o <= RING_HI));
endmodule

bind ring_ptr_writer ring_ptr_chk #(
  .RING_LO     (RING_LO),
  .RING_HI     (RING_HI),
  .MIRROR_BASE (MIRROR_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o)
);

// File: tb/tb_ring_ptr_writer.sv
module tb_ring_ptr_writer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_data_i = '0;
  logic        mem_valid_o;
  logic        mem_ready_i = 1'b0;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_cyc = 0;
  int n_bytes = 0;
  logic        stall_prev = 1'b0;
  logic [15:0] prev_addr = '0;
  logic [7:0]  prev_data = '0;
  logic [15:0] exp_ptr = 16'h0002;
  logic [25:0] exp_q[$];  // {tag, addr, data}

  always #10 clk_i = ~clk_i;  // 50 MHz

  ring_ptr_writer dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
  );

  function automatic logic [15:0] nxt(input logic [15:0] p);
    return (p == 16'h1000) ? 16'h0002 : p + 16'd1;
  endfunction

  function automatic string tag_name(input logic [1:0] t);
    case (t)
      2'd0: return "R1";
      2'd1: return "R4";
      2'd2: return "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic push_mirror(input logic [15:0] p, input logic [1:0] t);
    exp_q.push_back({t, 16'h0000, p[7:0]});
    exp_q.push_back({t, 16'h0001, p[15:8]});
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; in_valid_i = 1'b0; mem_ready_i = 1'b0;
    exp_q.delete(); stall_prev = 1'b0; exp_ptr = 16'h0002;
    push_mirror(16'h0002, 2'd0);  // R1
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic step(input int p_ready, input int p_valid);
    logic rdy;
    logic [25:0] e;
    logic [7:0] b;
    logic [15:0] np;
    @(negedge clk_i);
    check("R3", {31'd0, in_ready_o}, {31'd0, exp_q.size() == 0});
    check("R2", {31'd0, mem_valid_o}, {31'd0, exp_q.size() != 0});
    if (stall_prev) check("R6", {8'd0, mem_addr_o, mem_data_o}, {8'd0, prev_addr, prev_data});
    rdy = ($urandom % 100) < p_ready;
    mem_ready_i = rdy;
    if (mem_valid_o && rdy && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      check(tag_name(e[25:24]), {8'd0, mem_addr_o, mem_data_o}, {8'd0, e[23:0]});
    end
    stall_prev = mem_valid_o && !rdy;
    prev_addr = mem_addr_o; prev_data = mem_data_o;
    b = 8'($urandom);
    in_data_i = b;
    in_valid_i = ($urandom % 100) < p_valid;  // also driven while busy: must be ignored (R3)
    if (in_valid_i && in_ready_o) begin
      np = nxt(exp_ptr);
      exp_q.push_back({2'd1, exp_ptr, b});
      push_mirror(np, (exp_ptr == 16'h1000) ? 2'd3 : 2'd2);
      exp_ptr = np;
      n_bytes++;
    end
  endtask

  always @(posedge clk_i) begin
    n_cyc++;
    if (n_cyc >= 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", n_cyc, 190000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    push_mirror(16'h0002, 2'd0);  // R1 reset mirror
    repeat (3) @(negedge clk_i);
    check("R1", {31'd0, in_ready_o}, 32'd0);
    rst_ni = 1'b1;
    // directed: five bytes, memory always ready (block-boundary remainder)
    while (n_bytes < 5) step(100, 100);
    while (exp_q.size() != 0) step(100, 0);
    // directed: heavy back-pressure
    while (n_bytes < 40) step(15, 100);
    // mid-run reset
    do_reset();
    n_bytes = 0;
    // random stream through the wrap (R5) and beyond
    while (n_bytes < 4200) step(70, 80);
    while (exp_q.size() != 0) step(50, 0);
    step(100, 0);
    check("R5", {16'd0, exp_ptr}, {16'd0, 16'h0002 + 16'd4200 - 16'd4095});
    finish_run();
  end
endmodule